// File: doc/BRIEF.md
# CPU Frame Injection Word Framer

This block turns one frame handed over by a CPU-side source into an ordered run of 32-bit words for a switch injection queue. Every output word carries a kind flag that tells the queue whether the word is a control write or a data write. A frame starts with a control word that marks the start of the frame. The internal frame header words follow, then the payload words. Short payloads are padded with zero words up to a fixed minimum cell. A closing control word carries the end-of-frame mark and a valid-bytes field. A single zero data word ends the frame and stands in for the CRC.

A frame is requested through a descriptor handshake that carries the payload length in bytes and the number of header words. Header and payload words then arrive on two separate valid/ready streams. All streams use the same rule. A word moves on a clock edge where both valid and ready are high. A source that raises valid keeps its word and valid steady until the transfer happens. The output stream follows the same rule. When the sink holds ready low, the framer holds its word and kind flag unchanged and drops nothing. Header and payload words pass through to the output combinationally, so their ready signals follow the output ready while that phase is active.

Top module: `inj_framer`

## Requirements
- R1: The first output word of every frame is a control word (kind flag 1) with value 0x0024_0000. This is start-of-frame at bit 18 and a gap size of 1 in the field starting at bit 21.
- R2: After the start word, exactly the descriptor's header word count of header words is forwarded unchanged and in order as data words (kind flag 0), before any payload word. hdr_ready is high only during this phase.
- R3: The payload stream supplies ceil(length/4) words. They are forwarded unchanged and in order as data words directly after the header words.
- R4: When fewer than 15 payload words were forwarded, zero data words are appended until 15 words have been emitted after the header words. Header words do not count toward the 15.
- R5: After the payload and padding words comes one control word with end-of-frame at bit 19, gap size 1 at bit 21, and the valid-bytes value in bits 17:16. Its value is 0x0028_0000 plus the valid-bytes value shifted left by 16.
- R6: The valid-bytes value is 0 when the length is below 60 bytes. Otherwise it is the length modulo 4.
- R7: The last word of a frame is a single all-zero data word, directly after the end control word.
- R8: A frame with zero payload bytes reads no payload word and still emits 15 zero padding words, the end word and the zero word.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_ctrl hold their values into the next cycle.
- R10: len_ready is low from the descriptor transfer until the frame's final zero word has been accepted. It is high again in the cycle after that transfer.
- R11: After reset, out_valid, hdr_ready and pay_ready are low and len_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_valid | input | 1 | Frame descriptor valid |
| len_ready | output | 1 | Framer idle, descriptor can be taken |
| len_bytes | input | LEN_W | Payload length in bytes |
| hdr_count | input | HDR_W | Number of header words |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header word taken this cycle if valid |
| hdr_data | input | 32 | Header word |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Payload word taken this cycle if valid |
| pay_data | input | 32 | Payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts output word |
| out_data | output | 32 | Output word |
| out_ctrl | output | 1 | Kind flag: 1 control write, 0 data write |

## Verification
A table of frames varies the payload length across both sides of the 60-byte cell. It covers empty payloads, lengths one byte short of a word boundary, exactly 60, and long frames with every remainder. It also varies the header count from none to several. Each frame's full word sequence is compared with one built in the bench. Short-frame cases separate correct padding and a forced-zero valid-bytes field from lengths at or above 60, where the remainder must appear. Frames with and without header words show whether the phase skipping is right. Some frames run with the sink withdrawing ready in a fixed pattern, which exposes lost or changed words during stalls. Every frame also checks that the descriptor port stays closed until the trailing zero word has been taken.

// File: rtl/inj_framer_pkg.sv
package inj_framer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SOF,
    PH_HDR,
    PH_PAY,
    PH_PAD,
    PH_EOF,
    PH_CRC
  } phase_t;

  localparam int          WORD_W   = 32;
  localparam int          GAP_LSB  = 21;
  localparam int          EOF_BIT  = 19;
  localparam int          SOF_BIT  = 18;
  localparam int          VLD_LSB  = 16;
  localparam logic [2:0]  GAP_ONE  = 3'd1;

  function automatic logic [WORD_W-1:0] ctrl_word(input logic sof,
                                                  input logic eof,
                                                  input logic [1:0] vld);
    logic [WORD_W-1:0] w;
    w = '0;
    w[GAP_LSB +: 3] = GAP_ONE;
    w[EOF_BIT]      = eof;
    w[SOF_BIT]      = sof;
    w[VLD_LSB +: 2] = vld;
    return w;
  endfunction

endpackage

// File: rtl/inj_framer_fsm.sv
module inj_framer_fsm
  import inj_framer_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int HDR_W      = 4,
  parameter int CELL_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [HDR_W-1:0] hdr_count,
  input  logic             word_fire,
  output phase_t           phase,
  output logic             len_ready,
  output logic [1:0]       vld_bytes
);

  localparam int MIN_WORDS = CELL_BYTES / 4;
  localparam int SENT_W    = $clog2(MIN_WORDS + 1);
  localparam logic [SENT_W-1:0] MIN_CNT = SENT_W'(MIN_WORDS);

  phase_t             phase_q, phase_d;
  logic [LEN_W-1:0]   len_q;
  logic [HDR_W-1:0]   hdr_left;
  logic [LEN_W-1:0]   pay_left;
  logic [SENT_W-1:0]  sent_q;
  logic [SENT_W-1:0]  sent_inc;
  logic [LEN_W:0]     len_round;
  logic               desc_fire;
  phase_t             after_hdr;

  assign len_ready = (phase_q == PH_IDLE);
  assign desc_fire = len_valid && len_ready;
  assign len_round = ({1'b0, len_bytes} + (LEN_W+1)'(3)) >> 2;
  assign sent_inc  = (sent_q == MIN_CNT) ? sent_q : sent_q + 1'b1;
  assign after_hdr = (pay_left != '0) ? PH_PAY : PH_PAD;
  assign vld_bytes = (len_q < LEN_W'(CELL_BYTES)) ? 2'd0 : len_q[1:0];
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (desc_fire) phase_d = PH_SOF;
      PH_SOF:  if (word_fire) phase_d = (hdr_left != '0) ? PH_HDR : after_hdr;
      PH_HDR:  if (word_fire && hdr_left == HDR_W'(1)) phase_d = after_hdr;
      PH_PAY:  if (word_fire && pay_left == LEN_W'(1))
                 phase_d = (sent_inc < MIN_CNT) ? PH_PAD : PH_EOF;
      PH_PAD:  if (word_fire && sent_inc == MIN_CNT) phase_d = PH_EOF;
      PH_EOF:  if (word_fire) phase_d = PH_CRC;
      PH_CRC:  if (word_fire) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      len_q    <= '0;
      hdr_left <= '0;
      pay_left <= '0;
      sent_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (desc_fire) begin
        len_q    <= len_bytes;
        hdr_left <= hdr_count;
        pay_left <= len_round[LEN_W-1:0];
        sent_q   <= '0;
      end else if (word_fire) begin
        if (phase_q == PH_HDR) hdr_left <= hdr_left - 1'b1;
        if (phase_q == PH_PAY) pay_left <= pay_left - 1'b1;
        if (phase_q == PH_PAY || phase_q == PH_PAD) sent_q <= sent_inc;
      end
    end
  end

  // R4: the end word is only reached once the cell minimum is filled
  p_pad_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EOF) |-> (sent_q == MIN_CNT));

  // R2: no payload word is taken while header words remain
  p_hdr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAY) |-> (hdr_left == '0));

  // R7: the zero word closes the frame
  p_crc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CRC && word_fire) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/inj_framer_mux.sv
module inj_framer_mux
  import inj_framer_pkg::*;
(
  input  phase_t       phase,
  input  logic [1:0]   vld_bytes,
  input  logic         hdr_valid,
  input  logic [31:0]  hdr_data,
  input  logic         pay_valid,
  input  logic [31:0]  pay_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [31:0]  out_data,
  output logic         out_ctrl,
  output logic         hdr_ready,
  output logic         pay_ready,
  output logic         word_fire
);

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_ctrl  = 1'b0;
    hdr_ready = 1'b0;
    pay_ready = 1'b0;
    unique case (phase)
      PH_SOF: begin
        out_valid = 1'b1;
        out_ctrl  = 1'b1;
        out_data  = ctrl_word(1'b1, 1'b0, 2'd0);
      end
      PH_HDR: begin
        out_valid = hdr_valid;
        out_data  = hdr_data;
        hdr_ready = out_ready;
      end
      PH_PAY: begin
        out_valid = pay_valid;
        out_data  = pay_data;
        pay_ready = out_ready;
      end
      PH_PAD, PH_CRC: out_valid = 1'b1;
      PH_EOF: begin
        out_valid = 1'b1;
        out_ctrl  = 1'b1;
        out_data  = ctrl_word(1'b0, 1'b1, vld_bytes);
      end
      default: out_valid = 1'b0;
    endcase
  end

  assign word_fire = out_valid && out_ready;

endmodule

// File: rtl/inj_framer.sv
module inj_framer
  import inj_framer_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int HDR_W      = 4,
  parameter int CELL_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_valid,
  output logic             len_ready,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [HDR_W-1:0] hdr_count,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [31:0]      hdr_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic [31:0]      pay_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_ctrl
);

  phase_t     phase;
  logic [1:0] vld_bytes;
  logic       word_fire;

  inj_framer_fsm #(
    .LEN_W      (LEN_W),
    .HDR_W      (HDR_W),
    .CELL_BYTES (CELL_BYTES)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_valid (len_valid),
    .len_bytes (len_bytes),
    .hdr_count (hdr_count),
    .word_fire (word_fire),
    .phase     (phase),
    .len_ready (len_ready),
    .vld_bytes (vld_bytes)
  );

  inj_framer_mux mux_i (
    .phase     (phase),
    .vld_bytes (vld_bytes),
    .hdr_valid (hdr_valid),
    .hdr_data  (hdr_data),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .hdr_ready (hdr_ready),
    .pay_ready (pay_ready),
    .word_fire (word_fire)
  );

  // R9: a stalled word stays put
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  // R7: an accepted end word is followed at once by the zero data word
  p_end_then_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_ctrl && out_data[EOF_BIT])
      |=> (out_valid && !out_ctrl && out_data == '0));

  // R10: a taken descriptor closes the descriptor port
  p_desc_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && len_ready) |=> !len_ready);

  // R2: at most one input port is open at a time
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({len_ready, hdr_ready, pay_ready}));

endmodule

// File: tb/inj_framer_tb.sv
module inj_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // frame table: length, header words, stall mode, expected valid-bytes, expected words
  localparam int V_LEN  [NV] = '{0, 0, 5, 59, 60, 61, 63, 72, 100, 102};
  localparam int V_HDR  [NV] = '{2, 0, 0, 1, 3, 2, 1, 0, 4, 1};
  localparam int V_STALL[NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 0};
  localparam int V_VLD  [NV] = '{0, 0, 0, 0, 0, 1, 3, 0, 0, 2};
  localparam int V_NW   [NV] = '{20, 18, 18, 19, 21, 21, 20, 21, 32, 30};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_valid = 1'b0;
  logic        len_ready;
  logic [15:0] len_bytes = '0;
  logic [3:0]  hdr_count = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [31:0] hdr_data = '0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic [31:0] pay_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_ctrl;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] exp_data [0:63];
  logic        exp_ctrl [0:63];
  string       exp_tag  [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inj_framer dut_i (
    .clk(clk), .rst_n(rst_n),
    .len_valid(len_valid), .len_ready(len_ready),
    .len_bytes(len_bytes), .hdr_count(hdr_count),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctrl(out_ctrl)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] hdr_word(input int f, input int i);
    return 32'hA000_0000 | (f << 16) | i;
  endfunction

  function automatic logic [31:0] pay_word(input int f, input int k);
    return 32'hC000_0000 | (f << 16) | (k + 1);
  endfunction

  task automatic build_expect(input int f);
    int len = V_LEN[f];
    int h = V_HDR[f];
    int pw = (len + 3) / 4;
    int body = (pw < 15) ? 15 : pw;
    int p = 0;
    exp_data[p] = 32'h0024_0000; exp_ctrl[p] = 1'b1; exp_tag[p] = "R1"; p++;
    for (int i = 0; i < h; i++) begin
      exp_data[p] = hdr_word(f, i); exp_ctrl[p] = 1'b0; exp_tag[p] = "R2"; p++;
    end
    for (int k = 0; k < body; k++) begin
      exp_data[p] = (k < pw) ? pay_word(f, k) : 32'h0;
      exp_ctrl[p] = 1'b0;
      exp_tag[p]  = (k < pw) ? "R3" : ((len == 0) ? "R8" : "R4");
      p++;
    end
    exp_data[p] = 32'h0028_0000 | (V_VLD[f] << 16); exp_ctrl[p] = 1'b1;
    exp_tag[p] = (len >= 60) ? "R6" : "R5"; p++;
    exp_data[p] = 32'h0; exp_ctrl[p] = 1'b0; exp_tag[p] = "R7"; p++;
    check(p == V_NW[f], "R4", "table word count", p, V_NW[f]);
  endtask

  task automatic send_desc(input int f);
    @(negedge clk);
    len_valid = 1'b1; len_bytes = 16'(V_LEN[f]); hdr_count = 4'(V_HDR[f]);
    #1;
    while (!len_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    len_valid = 1'b0;
  endtask

  task automatic send_hdr(input int f);
    int n = V_HDR[f];
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      hdr_valid = 1'b1; hdr_data = hdr_word(f, i);
      #1;
      while (!hdr_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    hdr_valid = 1'b0;
  endtask

  task automatic send_pay(input int f);
    int n = (V_LEN[f] + 3) / 4;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      pay_valid = 1'b1; pay_data = pay_word(f, k);
      #1;
      while (!pay_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    pay_valid = 1'b0;
  endtask

  task automatic collect(input int f);
    int n = V_NW[f];
    int pos = 0;
    logic held = 1'b0;
    logic [31:0] hd = '0;
    logic hc = 1'b0;
    logic busy_open = 1'b0;
    while (pos < n) begin
      @(negedge clk);
      out_ready = (V_STALL[f] != 0) ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (held)
        check(out_valid && out_data == hd && out_ctrl == hc, "R9", "stall hold",
              out_data, hd);
      if (pos > 0 && len_ready) busy_open = 1'b1;
      if (out_valid && out_ready) begin
        check(out_data == exp_data[pos], exp_tag[pos], "word data", out_data, exp_data[pos]);
        check(out_ctrl == exp_ctrl[pos], exp_tag[pos], "kind flag",
              32'(out_ctrl), 32'(exp_ctrl[pos]));
        pos++;
      end
      held = out_valid && !out_ready;
      hd = out_data; hc = out_ctrl;
    end
    check(!busy_open, "R10", "descriptor port open mid-frame", 32'(busy_open), 0);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(!out_valid, "R7", "no word after zero word", 32'(out_valid), 0);
    check(len_ready, "R10", "descriptor port reopens", 32'(len_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R11", "out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R11", "out_valid after reset", 32'(out_valid), 0);
    check(len_ready, "R11", "len_ready after reset", 32'(len_ready), 1);
    check(!hdr_ready && !pay_ready, "R11", "stream readies after reset",
          {30'd0, hdr_ready, pay_ready}, 0);

    for (int f = 0; f < NV; f++) begin
      build_expect(f);
      fork
        send_desc(f);
        send_hdr(f);
        send_pay(f);
        collect(f);
      join
    end

    // directed: zero-length frame must never open the payload port (R8)
    begin
      int opened = 0;
      build_expect(1);
      fork
        send_desc(1);
        collect(1);
        begin
          repeat (30) begin @(negedge clk); #1; if (pay_ready) opened++; end
        end
      join
      check(opened == 0, "R8", "payload port opened for empty frame", opened, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule